// File: doc/BRIEF.md
# Load-Use Stall and Decode-Branch Flush Controller

This block is the hazard controller of a five-stage in-order pipeline. It watches the instruction that has just left decode and the instruction that now sits in decode. When the instruction ahead is a load whose destination register is a source of the decode instruction, the block freezes the program counter and the fetch/decode register. It also selects an all-zero control bundle for the execute stage, which turns that slot into a bubble that writes nothing.

Branches are resolved in decode. The block compares the two operand values read in decode for equality. When a branch is taken, or a jump sits in decode, it raises the redirect select, which steers the PC to the target computed elsewhere. It also raises a flush that zeroes the one instruction fetched behind it, so the slot becomes a nop (all-zero word). Fetch falls through by default, so a branch costs nothing unless it is taken. A load-use stall outranks any redirect. While the stall lasts, the branch waits in decode and is evaluated again on the first cycle after the stall ends. All outputs are combinational and take effect at the next rising edge. The clock and reset are used only to sample the embedded checks.

Top module: `stall_flush_ctrl`

## Requirements
- R1: `bubble_sel` is 1 exactly when `ex_is_load` is 1, `ex_dst` is nonzero, and `ex_dst` equals `dec_src_a` or `dec_src_b`.
- R2: While `bubble_sel` is 1, `pc_we` and `fd_we` are both 0. While it is 0, both are 1.
- R3: An `ex_dst` of 0 never raises a stall, whatever the source fields.
- R4: A branch in decode (`dec_branch`=1) with `dec_opnd_a` equal to `dec_opnd_b`, and no stall, drives `redirect`=1 and `fd_flush`=1 in the same cycle.
- R5: A branch whose operands differ is not taken: `redirect`=0 and `fd_flush`=0, so fetch falls through.
- R6: A jump in decode (`dec_jump`=1) with no stall always drives `redirect`=1 and `fd_flush`=1, whatever the operand values.
- R7: During a stall, `redirect` and `fd_flush` are 0 even if a taken branch or a jump is in decode. Once the stall clears with the same decode inputs, the branch or jump resolves normally.
- R8: `fd_flush` equals `redirect` at all times, and a flush is always given with `pc_we`=1 and `fd_we`=1.
- R9: With neither `dec_branch` nor `dec_jump` set, `redirect` and `fd_flush` stay 0.
- R10: Outputs depend only on the current inputs and respond in the same cycle, with no internal state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for the embedded checks |
| rst_n | input | 1 | Synchronous active-low reset, disables the checks |
| ex_is_load | input | 1 | Instruction in execute reads data memory |
| ex_dst | input | REG_AW | Destination register of the load in execute |
| dec_src_a | input | REG_AW | First source register field of the decode instruction |
| dec_src_b | input | REG_AW | Second source register field of the decode instruction |
| dec_branch | input | 1 | Decode instruction is a branch-if-equal |
| dec_jump | input | 1 | Decode instruction is an unconditional jump |
| dec_opnd_a | input | XLEN | First register value read in decode |
| dec_opnd_b | input | XLEN | Second register value read in decode |
| pc_we | output | 1 | PC update enable |
| fd_we | output | 1 | Fetch/decode register write enable |
| bubble_sel | output | 1 | Selects the all-zero control bundle into execute |
| fd_flush | output | 1 | Zeroes the fetch/decode instruction at the next edge |
| redirect | output | 1 | PC source select: 1 takes the branch/jump target |

## Verification
The bench builds the block with REG_AW=3, XLEN=8 and the lane-split comparator with LANE_W=2. Narrow register fields make matches between a load destination and a source field, including register 0, common under random stimulus. Narrow operands make random equal operand pairs frequent, so taken and not-taken branches both occur often. Differences confined to a single 2-bit lane check that every lane of the split comparator counts. Directed sequences cover a stall and a redirect in the same cycle, and the retry of the branch after the stall releases.

// File: rtl/hzc_pkg.sv
// Package: shared control-bundle type for the stall/flush controller.
// Assumes: all fields are single-bit enables, active high.
package hzc_pkg;
    typedef struct packed {
        logic pc_we;
        logic fd_we;
        logic bubble;
        logic flush;
        logic redirect;
    } hz_ctl_t;
endpackage

// File: rtl/load_use_detect.sv
// Module: load_use_detect
// Detects a load in execute whose destination is a source of the decode
// instruction. Assumes register 0 is hard-wired and never a real dependency.
module load_use_detect #(
    parameter int REG_AW = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ex_is_load,
    input  logic [REG_AW-1:0] ex_dst,
    input  logic [REG_AW-1:0] dec_src_a,
    input  logic [REG_AW-1:0] dec_src_b,
    output logic              stall
);
    localparam logic [REG_AW-1:0] ZERO_REG = '0;

    logic hit_a;
    logic hit_b;
    logic dst_live;

    // Purpose: compare the load destination against both source fields.
    always_comb begin
        dst_live = (ex_dst != ZERO_REG);
        hit_a    = (ex_dst == dec_src_a);
        hit_b    = (ex_dst == dec_src_b);
        stall    = ex_is_load && dst_live && (hit_a || hit_b);
    end

    // R3: register 0 as destination never stalls
    a_r3_zero_dst_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_dst == ZERO_REG) |-> !stall);

    // R1: no load in execute, no stall
    a_r1_no_load_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
        !ex_is_load |-> !stall);
endmodule

// File: rtl/branch_resolve.sv
// Module: branch_resolve
// Decides in decode whether control flow leaves the fall-through path.
// Compares the operands for equality, either flat or as lanes whose results
// are AND-reduced. Assumes XLEN is a multiple of LANE_W when SPLIT_CMP=1.
module branch_resolve #(
    parameter int XLEN      = 32,
    parameter bit SPLIT_CMP = 1'b1,
    parameter int LANE_W    = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            dec_branch,
    input  logic            dec_jump,
    input  logic [XLEN-1:0] opnd_a,
    input  logic [XLEN-1:0] opnd_b,
    output logic            take
);
    localparam int NLANES = (XLEN + LANE_W - 1) / LANE_W;

    logic ops_equal;

    generate
        if (SPLIT_CMP) begin : g_lanes
            logic [NLANES-1:0] lane_eq;
            for (genvar i = 0; i < NLANES; i++) begin : g_lane
                // Purpose: equality of one operand lane.
                always_comb lane_eq[i] = (opnd_a[i*LANE_W +: LANE_W] == opnd_b[i*LANE_W +: LANE_W]);
            end
            // Purpose: combine lane results into the full equality.
            always_comb ops_equal = &lane_eq;
        end else begin : g_flat
            // Purpose: single wide equality comparison.
            always_comb ops_equal = (opnd_a == opnd_b);
        end
    endgenerate

    // Purpose: raw redirect request before stall arbitration.
    always_comb take = dec_jump || (dec_branch && ops_equal);

    // R5: a branch with differing operands does not request a redirect
    a_r5_unequal_not_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_branch && !dec_jump && (opnd_a != opnd_b)) |-> !take);

    // R6: a jump always requests a redirect
    a_r6_jump_requests: assert property (@(posedge clk) disable iff (!rst_n)
        dec_jump |-> take);
endmodule

// File: rtl/hazard_arbiter.sv
// Module: hazard_arbiter
// Combines the stall and redirect requests into the control bundle.
// The stall has priority: a stalled decode instruction is never redirected.
module hazard_arbiter
    import hzc_pkg::*;
(
    input  logic    stall,
    input  logic    take,
    output hz_ctl_t ctl
);
    // Purpose: prioritise stall over redirect and form the enables.
    always_comb begin
        ctl.bubble   = stall;
        ctl.pc_we    = !stall;
        ctl.fd_we    = !stall;
        ctl.redirect = take && !stall;
        ctl.flush    = take && !stall;
    end
endmodule

// File: rtl/stall_flush_ctrl.sv
// Module: stall_flush_ctrl (top)
// Load-use stall generation plus decode-stage branch/jump resolution.
// Outputs are combinational; the pipeline registers act on them at the next
// rising edge. clk/rst_n only sample the embedded checks.
module stall_flush_ctrl
    import hzc_pkg::*;
#(
    parameter int REG_AW    = 5,
    parameter int XLEN      = 32,
    parameter bit SPLIT_CMP = 1'b1,
    parameter int LANE_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ex_is_load,
    input  logic [REG_AW-1:0] ex_dst,
    input  logic [REG_AW-1:0] dec_src_a,
    input  logic [REG_AW-1:0] dec_src_b,
    input  logic              dec_branch,
    input  logic              dec_jump,
    input  logic [XLEN-1:0]   dec_opnd_a,
    input  logic [XLEN-1:0]   dec_opnd_b,
    output logic              pc_we,
    output logic              fd_we,
    output logic              bubble_sel,
    output logic              fd_flush,
    output logic              redirect
);
    logic    stall;
    logic    take;
    hz_ctl_t ctl;

    load_use_detect #(.REG_AW(REG_AW)) i_detect (
        .clk(clk), .rst_n(rst_n),
        .ex_is_load(ex_is_load), .ex_dst(ex_dst),
        .dec_src_a(dec_src_a), .dec_src_b(dec_src_b),
        .stall(stall)
    );

    branch_resolve #(.XLEN(XLEN), .SPLIT_CMP(SPLIT_CMP), .LANE_W(LANE_W)) i_resolve (
        .clk(clk), .rst_n(rst_n),
        .dec_branch(dec_branch), .dec_jump(dec_jump),
        .opnd_a(dec_opnd_a), .opnd_b(dec_opnd_b),
        .take(take)
    );

    hazard_arbiter i_arb (
        .stall(stall), .take(take), .ctl(ctl)
    );

    // Purpose: drive the ports from the arbitrated bundle.
    always_comb begin
        pc_we      = ctl.pc_we;
        fd_we      = ctl.fd_we;
        bubble_sel = ctl.bubble;
        fd_flush   = ctl.flush;
        redirect   = ctl.redirect;
    end

    // R2: a bubble freezes the PC and fetch/decode register
    a_r2_hold_on_bubble: assert property (@(posedge clk) disable iff (!rst_n)
        bubble_sel |-> (!pc_we && !fd_we));

    // R7: no redirect or flush while stalled
    a_r7_stall_blocks_redirect: assert property (@(posedge clk) disable iff (!rst_n)
        bubble_sel |-> (!redirect && !fd_flush));

    // R8: a flush comes with redirect and advancing enables
    a_r8_flush_advances: assert property (@(posedge clk) disable iff (!rst_n)
        fd_flush |-> (redirect && pc_we && fd_we));

    // R9: no control-transfer instruction, no redirect
    a_r9_idle_no_redirect: assert property (@(posedge clk) disable iff (!rst_n)
        (!dec_branch && !dec_jump) |-> (!redirect && !fd_flush));
endmodule

// File: tb/test_stall_flush_ctrl.sv
`timescale 1ns/1ps
module test_stall_flush_ctrl;
    localparam int AW = 3;
    localparam int XW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ex_is_load = 1'b0;
    logic [AW-1:0] ex_dst = '0, dec_src_a = '0, dec_src_b = '0;
    logic          dec_branch = 1'b0, dec_jump = 1'b0;
    logic [XW-1:0] dec_opnd_a = '0, dec_opnd_b = '0;
    logic          pc_we, fd_we, bubble_sel, fd_flush, redirect;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    stall_flush_ctrl #(.REG_AW(AW), .XLEN(XW), .SPLIT_CMP(1'b1), .LANE_W(2)) i_stall_flush_ctrl (
        .clk(clk), .rst_n(rst_n), .ex_is_load(ex_is_load), .ex_dst(ex_dst),
        .dec_src_a(dec_src_a), .dec_src_b(dec_src_b),
        .dec_branch(dec_branch), .dec_jump(dec_jump),
        .dec_opnd_a(dec_opnd_a), .dec_opnd_b(dec_opnd_b),
        .pc_we(pc_we), .fd_we(fd_we), .bubble_sel(bubble_sel),
        .fd_flush(fd_flush), .redirect(redirect)
    );

    task automatic chk(input string tag, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
        end
    endtask

    // Behavioural reference: expected outputs from the requirements.
    task automatic compare_all(input string tag);
        bit dep, xfer, stl;
        dep  = (ex_dst == dec_src_a) || (ex_dst == dec_src_b);
        stl  = ex_is_load && (ex_dst != 0) && dep;
        xfer = dec_jump || (dec_branch && (dec_opnd_a == dec_opnd_b));
        if (xfer && stl) xfer = 0;
        chk(tag, "bubble_sel", bubble_sel, stl);
        chk(tag, "pc_we", pc_we, !stl);
        chk(tag, "fd_we", fd_we, !stl);
        chk(tag, "redirect", redirect, xfer);
        chk(tag, "fd_flush", fd_flush, xfer);
    endtask

    task automatic apply(input bit ld, input int dst, input int sa, input int sb,
                         input bit br, input bit jp, input int oa, input int ob);
        @(negedge clk);
        ex_is_load = ld; ex_dst = AW'(dst); dec_src_a = AW'(sa); dec_src_b = AW'(sb);
        dec_branch = br; dec_jump = jp; dec_opnd_a = XW'(oa); dec_opnd_b = XW'(ob);
        #1;
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // reset state with idle inputs (R10: purely combinational response)
        compare_all("R10");
        @(negedge clk) rst_n = 1'b1;

        // R1: match on source A and on source B
        apply(1, 3, 3, 5, 0, 0, 0, 0); compare_all("R1");
        chk("R1", "stall src_a", bubble_sel, 1'b1);
        apply(1, 4, 1, 4, 0, 0, 0, 0); compare_all("R1");
        chk("R2", "pc hold", pc_we, 1'b0);
        // R1: no load, same register -> no stall
        apply(0, 4, 4, 4, 0, 0, 0, 0); chk("R1", "non-load", bubble_sel, 1'b0);
        // R3: register 0 destination
        apply(1, 0, 0, 0, 0, 0, 0, 0); chk("R3", "zero dst", bubble_sel, 1'b0);
        chk("R3", "zero dst pc_we", pc_we, 1'b1);
        // R4: taken branch
        apply(0, 1, 2, 3, 1, 0, 8'h5A, 8'h5A);
        chk("R4", "redirect", redirect, 1'b1); chk("R4", "flush", fd_flush, 1'b1);
        chk("R8", "flush with pc_we", pc_we, 1'b1);
        // R5: operands differ in one 2-bit lane only
        for (int l = 0; l < 4; l++) begin
            apply(0, 1, 2, 3, 1, 0, 8'hC3, 8'hC3 ^ (1 << (2 * l + 1)));
            chk("R5", "not taken", redirect, 1'b0); chk("R5", "no flush", fd_flush, 1'b0);
        end
        // R6: jump with unequal operands
        apply(0, 1, 2, 3, 0, 1, 1, 2);
        chk("R6", "jump redirect", redirect, 1'b1); chk("R6", "jump flush", fd_flush, 1'b1);
        // R7: stall collides with taken branch, then retried
        apply(1, 2, 2, 6, 1, 0, 7, 7);
        chk("R7", "stalled redirect", redirect, 1'b0); chk("R7", "stalled flush", fd_flush, 1'b0);
        chk("R7", "stall wins", bubble_sel, 1'b1);
        apply(0, 2, 2, 6, 1, 0, 7, 7);
        chk("R7", "retry redirect", redirect, 1'b1); chk("R7", "retry flush", fd_flush, 1'b1);
        apply(1, 6, 2, 6, 0, 1, 0, 1);
        chk("R7", "stalled jump", redirect, 1'b0);
        // R9: idle decode with equal operands
        apply(0, 0, 0, 0, 0, 0, 9, 9); chk("R9", "idle", redirect, 1'b0);

        // Random stimulus compared on every clock against the reference
        for (int n = 0; n < 3000; n++) begin
            apply($urandom_range(0, 1), $urandom_range(0, 7), $urandom_range(0, 7),
                  $urandom_range(0, 7), $urandom_range(0, 1), ($urandom_range(0, 5) == 0),
                  $urandom_range(0, 7), $urandom_range(0, 7));
            compare_all("R8");
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule